// File: doc/BRIEF.md
# 16-bit Capture/Reload Timer

This block is a 16-bit timer with a 16-bit companion register that serves either as a capture register or as a reload value. An external control input drives it in one of three ways. It can trigger a capture of the running count. It can trigger a reload of the count. It can also set the count direction. Two faster modes reuse the same counter: baud-rate generation, which produces a one-clock tick for a serial unit, and clock-out, which toggles an output pin on every overflow.

Software configures the block through a small write port. The port selects one of four targets: the mode bits, the counter, the companion register, or a flag-clear command. An overflow flag and an external-event flag stay set until cleared. In the two normal modes, the timer advances once every twelve clocks. In baud and clock-out modes, it advances once every two clocks. The reload register is shared by the baud and clock-out rates, so these two rates cannot be set independently.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the counter, the companion register, both flags, `clkOut` and `baudTick` are zero, and all mode bits are zero, so the timer does not advance.
- R2: A write with `wrEn` high updates the target chosen by `wrSel`: 0 = mode bits, 1 = counter, 2 = companion register, 3 = flag clear. The mode bit positions are: bit0 run, bit1 capture mode, bit2 external enable, bit3 receive-baud select, bit4 transmit-baud select, bit5 clock-out enable, bit6 down-count enable. A counter write takes effect on the write edge.
- R3: In the normal modes with run set, the counter advances on the 12th clock edge after the mode write and then on every 12th edge. With run clear, the counter holds its value.
- R4: In capture mode, the counter counts up and wraps from 0xFFFF to 0x0000. The wrap sets the overflow flag and leaves the companion register unchanged.
- R5: In capture mode with external enable set, a falling edge on `extPin` copies the count that was held before that tick into the companion register and sets the external flag. With external enable clear, a falling edge has no effect.
- R6: In reload mode (capture mode clear), an up-count step from 0xFFFF loads the companion register value and sets the overflow flag.
- R7: In reload mode with external enable set and down-count enable clear, a falling edge on `extPin` loads the companion register value into the counter and sets the external flag.
- R8: In reload mode with down-count enable set, `extPin` sets the direction: 1 counts up and 0 counts down. When counting down, a step at a count equal to the companion register value loads 0xFFFF and sets the overflow flag.
- R9: When either baud select or clock-out enable is set, the timer advances every 2 clocks and reloads on overflow, even when capture mode is set.
- R10: In baud mode, each overflow produces a `baudTick` pulse that lasts exactly one clock.
- R11: With clock-out enable set, `clkOut` toggles on each overflow. When baud and clock-out modes are active together, they share the same overflow.
- R12: A flag-clear write clears the overflow flag if data bit0 is set and the external flag if data bit1 is set. Both flags otherwise stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target select |
| wrData | input | 16 | Write data |
| extPin | input | 1 | External trigger / direction input |
| count | output | 16 | Current counter value |
| capReload | output | 16 | Capture / reload register |
| ovfFlag | output | 1 | Overflow / underflow flag |
| extFlag | output | 1 | External-event flag |
| baudTick | output | 1 | One-clock pulse per overflow in baud mode |
| clkOut | output | 1 | Clock-out pin, toggles per overflow |

## Verification
Each mode is driven from a known start count near its boundary, so that one or two ticks show whether the wrap, the reload or the underflow went to the right value. Capture mode is tried with external enable on and then off. This separates a true capture from a capture that fires on any pin edge. The down-count run flips `extPin` in the middle of the run, which shows that the pin controls direction and does not trigger a reload. The fast-mode runs set capture mode together with baud select, which exposes an override that failed to force reload. Baud and clock-out are then run together, which checks that they share one reload value.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef struct packed {
    logic downEn;
    logic clkOutEn;
    logic txBaud;
    logic rxBaud;
    logic extEn;
    logic capMode;
    logic run;
  } timer_mode_t;

  typedef struct packed {
    logic loadCnt;
    logic loadCap;
    logic inc;
    logic dec;
    logic reload;
    logic setMax;
    logic capture;
    logic setOvf;
    logic setExt;
    logic clrOvf;
    logic clrExt;
    logic toggle;
    logic baudPulse;
  } timer_strobe_t;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CAP   = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [1:0]    clrBits,
  input  logic [6:0]    modeData,
  input  logic          extPin,
  input  logic          atMax,
  input  logic          atReload,
  output timer_strobe_t stb
);

  localparam int PRE_W = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV) : $clog2(FAST_DIV);

  timer_mode_t mode;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLast;
  logic extSamp;
  logic modeWr;
  logic preTick;
  logic tick;
  logic fastMode;
  logic baudMode;
  logic reloadMode;
  logic dirCtrl;
  logic goDown;
  logic extFall;

  assign modeWr     = wrEn && (wrSel == SEL_MODE);
  assign baudMode   = mode.rxBaud || mode.txBaud;
  assign fastMode   = baudMode || mode.clkOutEn;
  assign reloadMode = !mode.capMode || fastMode;
  assign dirCtrl    = mode.downEn && reloadMode && !fastMode;
  assign goDown     = dirCtrl && !extPin;
  assign divLast    = fastMode ? PRE_W'(FAST_DIV - 1) : PRE_W'(SLOW_DIV - 1);
  assign preTick    = (preCnt >= divLast) && !modeWr;
  assign tick       = preTick && mode.run;
  assign extFall    = preTick && extSamp && !extPin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= '0;
      preCnt  <= '0;
      extSamp <= 1'b0;
    end else begin
      if (modeWr) begin
        mode   <= timer_mode_t'(modeData);
        preCnt <= '0;
      end else if (preCnt >= divLast) begin
        preCnt <= '0;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      if (preTick) extSamp <= extPin;
    end
  end

  always_comb begin
    stb         = '0;
    stb.loadCnt = wrEn && (wrSel == SEL_COUNT);
    stb.loadCap = wrEn && (wrSel == SEL_CAP);
    stb.clrOvf  = wrEn && (wrSel == SEL_CLEAR) && clrBits[0];
    stb.clrExt  = wrEn && (wrSel == SEL_CLEAR) && clrBits[1];
    if (tick) begin
      if (goDown) begin
        if (atReload) begin
          stb.setMax = 1'b1;
          stb.setOvf = 1'b1;
        end else begin
          stb.dec = 1'b1;
        end
      end else if (atMax) begin
        stb.setOvf    = 1'b1;
        stb.toggle    = mode.clkOutEn;
        stb.baudPulse = baudMode;
        if (reloadMode) stb.reload = 1'b1;
        else            stb.inc    = 1'b1;
      end else begin
        stb.inc = 1'b1;
      end
      if (mode.extEn && extFall && !dirCtrl) begin
        stb.setExt = 1'b1;
        if (!fastMode) begin
          if (mode.capMode) stb.capture = 1'b1;
          else              stb.reload  = 1'b1;
        end
      end
    end
  end

  // R3: advances are at least two clocks apart
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc || stb.dec || stb.reload || stb.setMax) |=> !(stb.inc || stb.dec || stb.setMax));

  // R9: in a fast mode the capture strobe never fires
  p_no_capture_fast_r9: assert property (@(posedge clk) disable iff (!rstN)
    fastMode |-> !stb.capture);

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  timer_strobe_t    stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capReload,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             baudTick,
  output logic             clkOut,
  output logic             atMax,
  output logic             atReload
);

  localparam logic [WIDTH-1:0] MAX_VAL = '1;

  assign atMax    = (count == MAX_VAL);
  assign atReload = (count == capReload);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      capReload <= '0;
      ovfFlag   <= 1'b0;
      extFlag   <= 1'b0;
      baudTick  <= 1'b0;
      clkOut    <= 1'b0;
    end else begin
      if (stb.loadCnt)     count <= wrData;
      else if (stb.reload) count <= capReload;
      else if (stb.setMax) count <= MAX_VAL;
      else if (stb.inc)    count <= count + 1'b1;
      else if (stb.dec)    count <= count - 1'b1;

      if (stb.loadCap)      capReload <= wrData;
      else if (stb.capture) capReload <= count;

      if (stb.setOvf)      ovfFlag <= 1'b1;
      else if (stb.clrOvf) ovfFlag <= 1'b0;

      if (stb.setExt)      extFlag <= 1'b1;
      else if (stb.clrExt) extFlag <= 1'b0;

      baudTick <= stb.baudPulse;
      if (stb.toggle) clkOut <= !clkOut;
    end
  end

  // R4: companion register moves only on a write or a capture
  p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadCap && !stb.capture) |=> $stable(capReload));

  // R3: with no advance or write the counter holds
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadCnt && !stb.reload && !stb.setMax && !stb.inc && !stb.dec) |=> $stable(count));

  // R10: baud pulse lasts one clock
  p_baud_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  // R12: overflow flag is sticky until cleared
  p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stb.clrOvf) |=> ovfFlag);

  // R11: clock-out changes only on a toggle strobe
  p_clkout_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.toggle |=> $stable(clkOut));

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import timer_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic             extPin,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capReload,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             baudTick,
  output logic             clkOut
);

  timer_strobe_t stb;
  logic atMax;
  logic atReload;

  timer_ctrl #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .clrBits  (wrData[1:0]),
    .modeData (wrData[6:0]),
    .extPin   (extPin),
    .atMax    (atMax),
    .atReload (atReload),
    .stb      (stb)
  );

  timer_datapath #(.WIDTH(WIDTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .count     (count),
    .capReload (capReload),
    .ovfFlag   (ovfFlag),
    .extFlag   (extFlag),
    .baudTick  (baudTick),
    .clkOut    (clkOut),
    .atMax     (atMax),
    .atReload  (atReload)
  );

endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic        extPin = 1'b1;
  logic [15:0] count;
  logic [15:0] capReload;
  logic        ovfFlag;
  logic        extFlag;
  logic        baudTick;
  logic        clkOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cap_reload_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .extPin(extPin), .count(count), .capReload(capReload), .ovfFlag(ovfFlag),
    .extFlag(extFlag), .baudTick(baudTick), .clkOut(clkOut)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n, int d);
    repeat (n * d) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(logic [15:0] cnt, logic [15:0] rel);
    wr(2'd0, 16'h0000);
    wr(2'd1, cnt);
    wr(2'd2, rel);
    wr(2'd3, 16'h0003);
  endtask

  task automatic t_reset;
    chk("R1 count", count, 16'h0);
    chk("R1 capReload", capReload, 16'h0);
    chk("R1 flags", {14'd0, ovfFlag, extFlag}, 16'h0);
    chk("R1 outs", {14'd0, baudTick, clkOut}, 16'h0);
    ticks(3, 12);
    chk("R1 no run", count, 16'h0);
  endtask

  task automatic t_upcount;
    setup(16'd100, 16'h0);
    chk("R2 count write", count, 16'd100);
    wr(2'd0, 16'h0003);
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R3 before 12th edge", count, 16'd100);
    @(posedge clk); @(negedge clk);
    chk("R3 first step", count, 16'd101);
    ticks(4, 12);
    chk("R3 five steps", count, 16'd105);
    wr(2'd0, 16'h0002);
    ticks(3, 12);
    chk("R3 stopped", count, 16'd105);
  endtask

  task automatic t_capture;
    setup(16'h1000, 16'h0);
    extPin = 1'b1;
    wr(2'd0, 16'h0007);
    ticks(3, 12);
    extPin = 1'b0;
    ticks(1, 12);
    chk("R5 captured", capReload, 16'h1003);
    chk("R5 ext flag", {15'd0, extFlag}, 16'h1);
    chk("R5 count", count, 16'h1004);
    extPin = 1'b1;
    wr(2'd3, 16'h0002);
    wr(2'd0, 16'h0003);
    ticks(1, 12);
    extPin = 1'b0;
    ticks(2, 12);
    chk("R5 disabled no capture", capReload, 16'h1003);
    chk("R5 disabled no flag", {15'd0, extFlag}, 16'h0);
    extPin = 1'b1;
  endtask

  task automatic t_wrap;
    setup(16'hFFFE, 16'h1234);
    wr(2'd0, 16'h0003);
    ticks(1, 12);
    chk("R4 no early flag", {15'd0, ovfFlag}, 16'h0);
    ticks(1, 12);
    chk("R4 wrap", count, 16'h0000);
    chk("R4 ovf flag", {15'd0, ovfFlag}, 16'h1);
    chk("R4 reg unchanged", capReload, 16'h1234);
    ticks(2, 12);
    chk("R12 flag sticky", {15'd0, ovfFlag}, 16'h1);
    wr(2'd3, 16'h0002);
    chk("R12 ovf kept by ext clear", {15'd0, ovfFlag}, 16'h1);
    wr(2'd3, 16'h0001);
    chk("R12 ovf cleared", {15'd0, ovfFlag}, 16'h0);
  endtask

  task automatic t_reload;
    setup(16'hFFFE, 16'hFFF0);
    wr(2'd0, 16'h0001);
    ticks(2, 12);
    chk("R6 reload", count, 16'hFFF0);
    chk("R6 ovf", {15'd0, ovfFlag}, 16'h1);
    ticks(1, 12);
    chk("R6 continue", count, 16'hFFF1);
  endtask

  task automatic t_extReload;
    setup(16'h0010, 16'h0200);
    extPin = 1'b1;
    wr(2'd0, 16'h0005);
    ticks(2, 12);
    chk("R7 pre", count, 16'h0012);
    extPin = 1'b0;
    ticks(1, 12);
    chk("R7 ext reload", count, 16'h0200);
    chk("R7 ext flag", {15'd0, extFlag}, 16'h1);
    extPin = 1'b1;
  endtask

  task automatic t_down;
    setup(16'h0007, 16'h0005);
    extPin = 1'b0;
    wr(2'd0, 16'h0045);
    ticks(1, 12);
    chk("R8 down step", count, 16'h0006);
    ticks(2, 12);
    chk("R8 underflow", count, 16'hFFFF);
    chk("R8 ovf", {15'd0, ovfFlag}, 16'h1);
    chk("R8 no ext action", {15'd0, extFlag}, 16'h0);
    extPin = 1'b1;
    ticks(1, 12);
    chk("R8 up overflow", count, 16'h0005);
  endtask

  task automatic t_baud;
    setup(16'hFFFE, 16'hFFFD);
    wr(2'd0, 16'h000B);
    ticks(1, 2);
    chk("R9 fast step", count, 16'hFFFF);
    ticks(1, 2);
    chk("R9 forced reload", count, 16'hFFFD);
    chk("R10 pulse high", {15'd0, baudTick}, 16'h1);
    @(negedge clk);
    chk("R10 pulse one clock", {15'd0, baudTick}, 16'h0);
  endtask

  task automatic t_clkOut;
    logic prev;
    setup(16'hFFFE, 16'hFFFE);
    prev = clkOut;
    wr(2'd0, 16'h0021);
    ticks(2, 2);
    chk("R11 toggle", {15'd0, clkOut}, {15'd0, !prev});
    chk("R11 reload", count, 16'hFFFE);
    ticks(2, 2);
    chk("R11 toggle back", {15'd0, clkOut}, {15'd0, prev});
    setup(16'hFFFC, 16'hFFFC);
    prev = clkOut;
    wr(2'd0, 16'h0031);
    ticks(3, 2);
    chk("R11 shared no toggle", {15'd0, clkOut}, {15'd0, prev});
    ticks(1, 2);
    chk("R11 shared toggle", {15'd0, clkOut}, {15'd0, !prev});
    chk("R11 shared baud", {15'd0, baudTick}, 16'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_upcount();
    t_capture();
    t_wrap();
    t_reload();
    t_extReload();
    t_down();
    t_baud();
    t_clkOut();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule